// File: doc/BRIEF.md
# I2C Bit-Level Master Sequencer

This block is the line-level engine of an I2C master. It takes one command at a time over a valid/ready handshake (open a transaction, close it, or send one byte) and turns each command into a fixed, minimal series of changes on two open-drain lines, SCL and SDA. Each line change is followed by a programmable wait, so a single parameter sets the bus speed. The default wait of 250 system clocks per phase gives a nominal 100 kHz bus from a 50 MHz clock.

A byte is sent most significant bit first. The master then releases SDA for a ninth clock pulse and reads the acknowledge from the slave. A start issued while a transaction is already open produces a repeated-start condition. When the slave leaves SDA high on the acknowledge pulse, the block closes the bus with a stop condition by itself and reports a busy error for that write. Each finished command gives a one-cycle result strobe. An output flag shows whether a transaction is currently open. Byte reads, clock stretching, arbitration and 10-bit addressing are not handled.

Top module: `i2c_bit_master`

## Requirements
- R1: After reset both line outputs are 1 (released), `cmd_ready` is 1, `res_valid` is 0 and `txn_open` is 0.
- R2: Command code 0 (start) from the idle bus pulls SDA low while SCL stays high, then pulls SCL low, and sets `txn_open`.
- R3: A start while `txn_open` is 1 gives, with every step that would not change a line skipped: SDA released with SCL low, SCL high, SDA low, SCL low.
- R4: Command code 1 (stop) with a transaction open drives SDA low if it is not already low, then releases SCL, then releases SDA, and clears `txn_open`. With no transaction open it completes with `res_err` 0 and changes no line.
- R5: Command code 2 (write) sends `cmd_data` most significant bit first. For each bit, SDA takes the bit value while SCL is low, then SCL goes high and back low. A line that already holds the wanted level is not changed, and no two line changes share one clock cycle.
- R6: After the eighth bit, SDA is released and one more SCL pulse is given. SDA is sampled in the middle of the SCL-high phase. A low sample means acknowledge: the write completes with `res_err` 0, no stop is sent and `txn_open` stays 1.
- R7: A high sample on the acknowledge pulse makes the block run the stop sequence of R4 by itself. The write then completes with `res_err` 1 and `txn_open` 0.
- R8: After any line change, both lines keep their levels for at least `PHASE_CLKS` clock cycles.
- R9: `cmd_ready` goes low in the cycle after a command is accepted and stays low until completion. `res_valid` is a one-cycle pulse, and `cmd_ready` is 1 in that same cycle.
- R10: Command code 3 is a no-op. It completes with `res_err` 0, changes no line and leaves `txn_open` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 0 start, 1 stop, 2 write, 3 no-op |
| cmd_data | input | BYTE_W | Byte to send for a write |
| res_valid | output | 1 | One-cycle completion strobe |
| res_err | output | 1 | 1 when a write got no acknowledge (busy error) |
| txn_open | output | 1 | A transaction is in progress |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA drive: 0 pulls low, 1 releases |
| sda_i | input | 1 | Level sensed on the SDA line |

## Verification
A wrong step index or segment choice shows at the line outputs within one phase. The bench catches it by recording every change of the line pair and comparing the full list to a sequence computed from the rules, for all 256 byte values under both acknowledge outcomes. A stale acknowledge capture or a corrupted transaction flag shows when the write completes, as a wrong `res_err` or a wrong `txn_open`, or one command later, as a missing or extra stop. A timer fault shows at the next line change as a level held too briefly.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_NOP   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    SEG_NONE  = 3'd0,
    SEG_START = 3'd1,
    SEG_STOP  = 3'd2,
    SEG_BIT   = 3'd3,
    SEG_ACK   = 3'd4
  } seg_e;

  // one entry of a line sequence
  typedef struct packed {
    logic on_sda;   // 1: step targets SDA, 0: targets SCL
    logic lvl;      // wanted level
    logic last;     // final step of its segment
    logic sample;   // capture SDA mid-phase while this step waits
  } step_t;

endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int PHASE_CLKS = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic done,
  output logic mid
);
  localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [CW-1:0] TOP_V = CW'(PHASE_CLKS - 1);
  localparam logic [CW-1:0] MID_V = CW'((PHASE_CLKS - 1) / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= TOP_V;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);
  assign mid  = (cnt_q == MID_V);
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] data,
  output logic              cur_bit,
  output logic              last_bit
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= data;
      left_q <= CNT_W'(BYTE_W - 1);
    end else if (shift) begin
      sh_q   <= sh_q << 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign cur_bit  = sh_q[BYTE_W-1];
  assign last_bit = (left_q == '0);
endmodule

// File: rtl/i2c_step_table.sv
module i2c_step_table
  import i2c_seq_pkg::*;
(
  input  seg_e       seg,
  input  logic [1:0] idx,
  input  logic       data_bit,
  output step_t      step
);
  always_comb begin
    step = '{on_sda: 1'b0, lvl: 1'b1, last: 1'b1, sample: 1'b0};
    unique case (seg)
      SEG_START: begin
        case (idx)
          2'd0:    step = '{on_sda: 1'b1, lvl: 1'b1, last: 1'b0, sample: 1'b0};
          2'd1:    step = '{on_sda: 1'b0, lvl: 1'b1, last: 1'b0, sample: 1'b0};
          2'd2:    step = '{on_sda: 1'b1, lvl: 1'b0, last: 1'b0, sample: 1'b0};
          default: step = '{on_sda: 1'b0, lvl: 1'b0, last: 1'b1, sample: 1'b0};
        endcase
      end
      SEG_STOP: begin
        case (idx)
          2'd0:    step = '{on_sda: 1'b1, lvl: 1'b0, last: 1'b0, sample: 1'b0};
          2'd1:    step = '{on_sda: 1'b0, lvl: 1'b1, last: 1'b0, sample: 1'b0};
          default: step = '{on_sda: 1'b1, lvl: 1'b1, last: 1'b1, sample: 1'b0};
        endcase
      end
      SEG_BIT: begin
        case (idx)
          2'd0:    step = '{on_sda: 1'b1, lvl: data_bit, last: 1'b0, sample: 1'b0};
          2'd1:    step = '{on_sda: 1'b0, lvl: 1'b1, last: 1'b0, sample: 1'b0};
          default: step = '{on_sda: 1'b0, lvl: 1'b0, last: 1'b1, sample: 1'b0};
        endcase
      end
      SEG_ACK: begin
        case (idx)
          2'd0:    step = '{on_sda: 1'b1, lvl: 1'b1, last: 1'b0, sample: 1'b0};
          2'd1:    step = '{on_sda: 1'b0, lvl: 1'b1, last: 1'b0, sample: 1'b1};
          default: step = '{on_sda: 1'b0, lvl: 1'b0, last: 1'b1, sample: 1'b0};
        endcase
      end
      default: step = '{on_sda: 1'b0, lvl: 1'b1, last: 1'b1, sample: 1'b0};
    endcase
  end
endmodule

// File: rtl/i2c_bit_master.sv
module i2c_bit_master
  import i2c_seq_pkg::*;
#(
  parameter int PHASE_CLKS = 250,  // 50 MHz / (2 * 100 kHz)
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_data,
  output logic              res_valid,
  output logic              res_err,
  output logic              txn_open,
  output logic              scl_o,
  output logic              sda_o,
  input  logic              sda_i
);
  logic busy_q, wait_q, scl_q, sda_q, txn_q, nack_q, auto_stop_q;
  logic rdy_q, resv_q, rese_q;
  seg_e seg_q;
  logic [1:0] idx_q;

  step_t step;
  logic  cur_bit, last_bit, tmr_done, tmr_mid;
  logic  cur_lvl, need_change, apply, adv, accept, load_sh, shift_en;

  assign accept = cmd_valid && rdy_q && !busy_q;

  i2c_step_table u_tbl (
    .seg      (seg_q),
    .idx      (idx_q),
    .data_bit (cur_bit),
    .step     (step)
  );

  always_comb begin
    cur_lvl     = step.on_sda ? sda_q : scl_q;
    need_change = (step.lvl != cur_lvl);
    apply       = busy_q && !wait_q && (seg_q != SEG_NONE) && need_change;
    if (!busy_q)                adv = 1'b0;
    else if (seg_q == SEG_NONE) adv = 1'b1;
    else if (wait_q)            adv = tmr_done;
    else                        adv = !need_change;
  end

  assign load_sh  = accept && (op_e'(cmd_op) == OP_WRITE);
  assign shift_en = adv && (seg_q == SEG_BIT) && step.last && !last_bit;

  i2c_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (apply),
    .run  (wait_q),
    .done (tmr_done),
    .mid  (tmr_mid)
  );

  i2c_byte_shift #(.BYTE_W(BYTE_W)) u_shf (
    .clk      (clk),
    .rst      (rst),
    .load     (load_sh),
    .shift    (shift_en),
    .data     (cmd_data),
    .cur_bit  (cur_bit),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      wait_q      <= 1'b0;
      scl_q       <= 1'b1;
      sda_q       <= 1'b1;
      txn_q       <= 1'b0;
      nack_q      <= 1'b0;
      auto_stop_q <= 1'b0;
      rdy_q       <= 1'b1;
      resv_q      <= 1'b0;
      rese_q      <= 1'b0;
      seg_q       <= SEG_NONE;
      idx_q       <= 2'd0;
    end else begin
      resv_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        rdy_q  <= 1'b0;
        idx_q  <= 2'd0;
        unique case (op_e'(cmd_op))
          OP_START: seg_q <= SEG_START;
          OP_STOP:  seg_q <= txn_q ? SEG_STOP : SEG_NONE;
          OP_WRITE: begin
            seg_q  <= SEG_BIT;
            nack_q <= 1'b0;
          end
          default:  seg_q <= SEG_NONE;
        endcase
      end

      if (apply) begin
        if (step.on_sda) sda_q <= step.lvl;
        else             scl_q <= step.lvl;
        wait_q <= 1'b1;
      end

      // acknowledge capture in the middle of the SCL-high phase
      if (busy_q && wait_q && step.sample && tmr_mid) begin
        nack_q <= sda_i;
      end

      if (adv) begin
        wait_q <= 1'b0;
        if (seg_q == SEG_NONE) begin
          busy_q <= 1'b0;
          rdy_q  <= 1'b1;
          resv_q <= 1'b1;
          rese_q <= 1'b0;
        end else if (!step.last) begin
          idx_q <= idx_q + 2'd1;
        end else begin
          idx_q <= 2'd0;
          unique case (seg_q)
            SEG_START: begin
              txn_q  <= 1'b1;
              busy_q <= 1'b0;
              rdy_q  <= 1'b1;
              resv_q <= 1'b1;
              rese_q <= 1'b0;
            end
            SEG_STOP: begin
              txn_q       <= 1'b0;
              busy_q      <= 1'b0;
              rdy_q       <= 1'b1;
              resv_q      <= 1'b1;
              rese_q      <= auto_stop_q;
              auto_stop_q <= 1'b0;
            end
            SEG_BIT: begin
              if (last_bit) seg_q <= SEG_ACK;
            end
            SEG_ACK: begin
              if (nack_q) begin
                seg_q       <= SEG_STOP;
                auto_stop_q <= 1'b1;
              end else begin
                busy_q <= 1'b0;
                rdy_q  <= 1'b1;
                resv_q <= 1'b1;
                rese_q <= 1'b0;
              end
            end
            default: begin
              busy_q <= 1'b0;
              rdy_q  <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign cmd_ready = rdy_q;
  assign res_valid = resv_q;
  assign res_err   = rese_q;
  assign txn_open  = txn_q;
  assign scl_o     = scl_q;
  assign sda_o     = sda_q;
endmodule

// File: rtl/i2c_bit_master_chk.sv
module i2c_bit_master_chk #(
  parameter int PHASE_CLKS = 250
) (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic res_valid,
  input logic txn_open,
  input logic scl_o,
  input logic sda_o
);
  localparam int HW = $clog2(PHASE_CLKS + 1) + 1;
  localparam logic [HW-1:0] SAT = HW'(PHASE_CLKS);

  logic [1:0]    prev_q;
  logic [HW-1:0] held_q;
  logic          chg;

  assign chg = ({scl_o, sda_o} != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 2'b11;
      held_q <= SAT;
    end else begin
      prev_q <= {scl_o, sda_o};
      if (chg)               held_q <= HW'(1);
      else if (held_q < SAT) held_q <= held_q + 1'b1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    $fell(rst) |-> (scl_o && sda_o && cmd_ready && !txn_open));

  assert_start_leaves_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(txn_open) |-> (!scl_o && !sda_o));

  assert_stop_releases_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(txn_open) |-> (scl_o && sda_o));

  assert_single_line_step_R5: assert property (@(posedge clk) disable iff (rst)
    $countones({scl_o ^ prev_q[1], sda_o ^ prev_q[0]}) <= 1);

  assert_phase_hold_R8: assert property (@(posedge clk) disable iff (rst)
    chg |-> (held_q >= SAT));

  assert_ready_drops_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_result_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_result_ready_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> cmd_ready);
endmodule

bind i2c_bit_master i2c_bit_master_chk #(.PHASE_CLKS(PHASE_CLKS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .res_valid (res_valid),
  .txn_open  (txn_open),
  .scl_o     (scl_o),
  .sda_o     (sda_o)
);

// File: tb/i2c_bit_master_tb.sv
`timescale 1ns/1ps
module i2c_bit_master_tb;
  localparam int PHASE = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'd0;
  logic slave_pull = 1'b0;
  logic cmd_ready, res_valid, res_err, txn_open, scl_o, sda_o, sda_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sda_i = sda_o & ~slave_pull;

  i2c_bit_master #(.PHASE_CLKS(PHASE), .BYTE_W(8)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .res_valid(res_valid),
    .res_err(res_err), .txn_open(txn_open), .scl_o(scl_o), .sda_o(sda_o),
    .sda_i(sda_i));

  // recorded line changes, {scl, sda}
  logic [1:0] hist [64];
  int hn = 0;
  logic [1:0] prev_lines = 2'b11;
  int last_chg = -1000;

  always @(negedge clk) begin
    if (!rst && ({scl_o, sda_o} != prev_lines)) begin
      if (hn < 64) hist[hn] = {scl_o, sda_o};
      hn++;
      checks++;
      if (cyc - last_chg < PHASE) begin
        errors++;
        $display("FAIL R8 hold: actual %0d cycles, expected >= %0d", cyc - last_chg, PHASE);
      end
      last_chg = cyc;
      prev_lines = {scl_o, sda_o};
    end
  end

  // expected sequence model
  logic [1:0] expv [64];
  int en = 0;
  logic m_scl = 1'b1, m_sda = 1'b1, m_txn = 1'b0;

  task automatic m_set(input bit on_sda, input bit lvl);
    if (on_sda ? (m_sda != lvl) : (m_scl != lvl)) begin
      if (on_sda) m_sda = lvl; else m_scl = lvl;
      if (en < 64) expv[en] = {m_scl, m_sda};
      en++;
    end
  endtask

  task automatic m_start();
    m_set(1, 1); m_set(0, 1); m_set(1, 0); m_set(0, 0);
    m_txn = 1'b1;
  endtask

  task automatic m_stop();
    if (m_txn) begin
      m_set(1, 0); m_set(0, 1); m_set(1, 1);
      m_txn = 1'b0;
    end
  endtask

  task automatic m_byte(input logic [7:0] d, input bit ack);
    for (int b = 7; b >= 0; b--) begin
      m_set(1, d[b]); m_set(0, 1); m_set(0, 0);
    end
    m_set(1, 1); m_set(0, 1); m_set(0, 0);
    if (!ack) m_stop();
  endtask

  task automatic clear_hist();
    hn = 0; en = 0;
  endtask

  task automatic cmp_hist(input string req);
    int bad;
    bad = -1;
    checks++;
    if (hn != en) begin
      errors++;
      $display("FAIL %s change count: actual %0d expected %0d", req, hn, en);
    end else begin
      for (int i = 0; i < en && i < 64; i++)
        if (bad < 0 && hist[i] != expv[i]) bad = i;
      if (bad >= 0) begin
        errors++;
        $display("FAIL %s change %0d: actual %b expected %b", req, bad, hist[bad], expv[bad]);
      end
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [7:0] d, output logic err);
    int guard;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 ready low after accept", cmd_ready, 1'b0);
    guard = 0;
    while (!res_valid && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    err = res_err;
    chk("R9 result seen", res_valid, 1'b1);
    chk("R9 ready with result", cmd_ready, 1'b1);
    @(negedge clk);
    chk("R9 result one cycle", res_valid, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 scl released", scl_o, 1'b1);
    chk("R1 sda released", sda_o, 1'b1);
    chk("R1 ready", cmd_ready, 1'b1);
    chk("R1 no result", res_valid, 1'b0);
    chk("R1 no txn", txn_open, 1'b0);

    // R2 then R4: start from idle, stop
    clear_hist();
    do_cmd(2'd0, 8'h00, e); m_start();
    chk("R2 txn set", txn_open, 1'b1);
    chk("R2 err", e, 1'b0);
    do_cmd(2'd1, 8'h00, e); m_stop();
    chk("R4 txn clear", txn_open, 1'b0);
    cmp_hist("R2/R4 start-stop");

    // R3 repeated start
    clear_hist();
    do_cmd(2'd0, 8'h00, e); m_start();
    do_cmd(2'd0, 8'h00, e); m_start();
    cmp_hist("R3 repeated start");
    slave_pull = 1'b1;
    do_cmd(2'd2, 8'h56, e); m_byte(8'h56, 1);
    do_cmd(2'd0, 8'h00, e); m_start();
    slave_pull = 1'b0;
    do_cmd(2'd1, 8'h00, e); m_stop();
    cmp_hist("R3 repeated start after write");

    // R4 stop without transaction
    clear_hist();
    do_cmd(2'd1, 8'h00, e);
    chk("R4 idle stop err", e, 1'b0);
    cmp_hist("R4 idle stop no change");

    // R10 no-op inside a transaction
    clear_hist();
    do_cmd(2'd0, 8'h00, e); m_start();
    do_cmd(2'd3, 8'hFF, e);
    chk("R10 nop err", e, 1'b0);
    chk("R10 nop txn kept", txn_open, 1'b1);
    cmp_hist("R10 nop no change");
    do_cmd(2'd1, 8'h00, e); m_stop();

    // R5/R6 sweep with acknowledge
    for (int d = 0; d < 256; d++) begin
      clear_hist();
      do_cmd(2'd0, 8'h00, e); m_start();
      slave_pull = 1'b1;
      do_cmd(2'd2, d[7:0], e); m_byte(d[7:0], 1);
      slave_pull = 1'b0;
      chk("R6 ack err", e, 1'b0);
      chk("R6 txn kept", txn_open, 1'b1);
      do_cmd(2'd1, 8'h00, e); m_stop();
      cmp_hist("R5 byte lines");
    end

    // R7 sweep without acknowledge
    for (int d = 0; d < 256; d++) begin
      clear_hist();
      do_cmd(2'd0, 8'h00, e); m_start();
      do_cmd(2'd2, d[7:0], e); m_byte(d[7:0], 0);
      chk("R7 busy err", e, 1'b1);
      chk("R7 txn cleared", txn_open, 1'b0);
      cmp_hist("R7 auto stop lines");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule